// File: doc/BRIEF.md
# Dual-Timing-Mode FIFO with Programmable Thresholds

This block is a two-clock first-in first-out buffer. Its read-side timing discipline is chosen once, at master reset, from a mode pin. In standard timing every word, the first one included, leaves the buffer only when the reader asks for it. The read flag then means "not empty" and the write flag means "not full". In fall-through timing the oldest word is placed on the read data port without any request. The read flag then means "output holds valid data" and the write flag means "room to accept a word". Later words still need a read request.

Pointers cross between the two clock domains as Gray codes through two-flop synchronizers, and every flag is derived from the synchronized pointers. The block also raises an almost-empty indication and lowers an almost-full indication from two offsets. These offsets are captured at reset from input pins when a load pin is high, or else taken from parameter defaults (127 for both). Occupancy means words written and not yet consumed by a read; in fall-through timing the word on the output counts until it is read.

States of the read controller: `RS_STD` (standard timing, reads on request), `RS_FT_DRY` (fall-through, output empty) and `RS_FT_WET` (fall-through, output valid). Reset enters `RS_STD` when the mode pin is low and `RS_FT_DRY` when it is high. `RS_FT_DRY` goes to `RS_FT_WET` when a synchronized word is present (load). `RS_FT_WET` stays in `RS_FT_WET` on a read while more than one word is held (advance), and goes back to `RS_FT_DRY` on a read of the last word (drain). `RS_STD` loops on itself.

Top module: `dual_mode_fifo`

## Requirements
- R1: The mode pin is sampled only while master reset is high (0 = standard, 1 = fall-through); changing it afterwards has no effect until the next reset.
- R2: In standard timing, rd_flag is 0 while empty, becomes 1 once a written word has crossed, and rd_data changes only on a read clock edge with rd_en=1 and rd_sel=1 while rd_flag=1.
- R3: In fall-through timing, the first word written into an empty buffer appears on rd_data with rd_flag=1 after exactly three read clock rising edges following the write edge, with no read request; rd_flag drops on the same edge that consumes the last word.
- R4: almost_empty is 1 when occupancy exceeds the empty offset n and 0 when occupancy is n or less.
- R5: almost_full_n is 0 when occupancy is at least DEPTH minus the full offset m, and 1 otherwise.
- R6: After DEPTH writes with no reads, wr_flag is 0 and further writes are discarded; the first read brings wr_flag back to 1.
- R7: A read request while empty changes nothing; rd_oe equals rd_sel as sampled at the previous read clock edge.
- R8: In standard timing, rd_flag follows the read-domain occupancy through two register stages: it falls on the second read edge after the edge that consumed the last word.
- R9: When ofs_load is high during reset, ae_offset and af_offset are captured as n and m; otherwise the parameter defaults are used; the pins are ignored after reset.
- R10: Words leave in the order they were written.
- R11: Right after reset, rd_flag=0, wr_flag=1, almost_empty=0, almost_full_n=1, rd_oe=0 and rd_data=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, synchronous in each domain |
| ft_mode | input | 1 | Timing mode select, sampled during reset |
| ofs_load | input | 1 | Take offsets from pins at reset |
| ae_offset | input | ADDR_W | Almost-empty offset n |
| af_offset | input | ADDR_W | Almost-full offset m |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 1 | Write select |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read enable |
| rd_sel | input | 1 | Read select |
| rd_data | output | DATA_W | Registered read data |
| rd_flag | output | 1 | Not-empty (standard) or output-valid (fall-through) |
| wr_flag | output | 1 | Not-full (standard) or input-ready (fall-through) |
| almost_empty | output | 1 | High above n words |
| almost_full_n | output | 1 | Low at DEPTH minus m words or more |
| rd_oe | output | 1 | Output-enable indication from rd_sel |

## Verification
The bench builds the block with ADDR_W=4 (16 words), DATA_W=8 and both default offsets set to 3. This small depth lets every occupancy from 0 to 16 be stepped through by single writes and single reads in both timing modes. It runs four reset setups: defaults, mid-range offsets, both offsets 0 and both offsets 15. The extremes put both threshold flags at their first and last possible occupancy. The three-edge fall-through latency and the two-stage empty flag fall are counted edge by edge, because the two clocks never share an edge.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
    typedef enum logic [1:0] {
        RS_STD    = 2'd0,
        RS_FT_DRY = 2'd1,
        RS_FT_WET = 2'd2
    } rd_state_e;
endpackage

// File: rtl/fifo_sync2.sv
module fifo_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fifo_gray2bin.sv
module fifo_gray2bin #(
    parameter int W = 5
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    assign bin[W-1] = gray[W-1];
    for (genvar i = W - 2; i >= 0; i--) begin : g_bit
        assign bin[i] = bin[i+1] ^ gray[i];
    end
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl #(
    parameter int ADDR_W       = 8,
    parameter int DEF_FULL_OFS = 127
) (
    input  logic              wr_clk,
    input  logic              mrst,
    input  logic              ft_mode,
    input  logic              ofs_load,
    input  logic [ADDR_W-1:0] af_offset,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [ADDR_W:0]   rptr_gray_s,
    output logic              wr_go,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   wptr_gray,
    output logic [ADDR_W:0]   wr_cnt,
    output logic              wr_flag,
    output logic              almost_full_n
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] FULL_CNT = PW'(1 << ADDR_W);
    localparam logic [PW:0]   FULL_EXT = (PW + 1)'(1 << ADDR_W);
    localparam logic [ADDR_W-1:0] DEF_M = ADDR_W'(DEF_FULL_OFS);

    logic [PW-1:0]     wptr;
    logic [PW-1:0]     rptr_s_bin;
    logic [ADDR_W-1:0] af_thr;
    logic              mode_q;
    logic              ff_s1;
    logic              ff_s2;

    fifo_gray2bin #(.W(PW)) i_rptr_g2b (.gray(rptr_gray_s), .bin(rptr_s_bin));

    assign wr_cnt    = wptr - rptr_s_bin;
    assign wr_go     = wr_en && wr_sel && (wr_cnt != FULL_CNT);
    assign wr_addr   = wptr[ADDR_W-1:0];
    assign wptr_gray = wptr ^ (wptr >> 1);
    assign wr_flag   = mode_q ? ff_s1 : ff_s2;

    always_ff @(posedge wr_clk) begin
        if (mrst) begin
            wptr          <= '0;
            mode_q        <= ft_mode;
            af_thr        <= ofs_load ? af_offset : DEF_M;
            ff_s1         <= 1'b1;
            ff_s2         <= 1'b1;
            almost_full_n <= 1'b1;
        end else begin
            if (wr_go) wptr <= wptr + 1'b1;
            ff_s1         <= (wr_cnt != FULL_CNT);
            ff_s2         <= ff_s1;
            almost_full_n <= ({1'b0, wr_cnt} + {2'b00, af_thr}) < FULL_EXT;
        end
    end
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
    import fifo_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8,
    parameter int DEF_EMPTY_OFS = 127
) (
    input  logic              rd_clk,
    input  logic              mrst,
    input  logic              ft_mode,
    input  logic              ofs_load,
    input  logic [ADDR_W-1:0] ae_offset,
    input  logic              rd_en,
    input  logic              rd_sel,
    input  logic [ADDR_W:0]   wptr_gray_s,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   rptr_gray,
    output logic [ADDR_W:0]   rd_cnt,
    output rd_state_e         state,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    output logic              almost_empty,
    output logic              rd_oe
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0]     ONE_CNT = PW'(1);
    localparam logic [ADDR_W-1:0] DEF_N   = ADDR_W'(DEF_EMPTY_OFS);

    logic [PW-1:0]     rptr;
    logic [PW-1:0]     wptr_s_bin;
    logic [ADDR_W-1:0] ae_thr;
    rd_state_e         nxt;
    logic              pop;
    logic              load;
    logic              ef_s1;
    logic              ef_s2;

    fifo_gray2bin #(.W(PW)) i_wptr_g2b (.gray(wptr_gray_s), .bin(wptr_s_bin));

    assign rd_cnt    = wptr_s_bin - rptr;
    assign rptr_gray = rptr ^ (rptr >> 1);
    assign rd_addr   = (state == RS_FT_WET) ? rptr[ADDR_W-1:0] + ADDR_W'(1)
                                            : rptr[ADDR_W-1:0];
    assign rd_flag   = (state == RS_STD) ? ef_s2 : (state == RS_FT_WET);

    // next state and transfer decisions
    always_comb begin
        nxt  = state;
        pop  = 1'b0;
        load = 1'b0;
        unique case (state)
            RS_STD: begin
                if (rd_en && rd_sel && ef_s2 && (rd_cnt != '0)) begin
                    pop  = 1'b1;
                    load = 1'b1;
                end
            end
            RS_FT_DRY: begin
                if (rd_cnt != '0) begin
                    load = 1'b1;
                    nxt  = RS_FT_WET;
                end
            end
            RS_FT_WET: begin
                if (rd_en && rd_sel) begin
                    pop = 1'b1;
                    if (rd_cnt > ONE_CNT) load = 1'b1;
                    else                  nxt  = RS_FT_DRY;
                end
            end
            default: nxt = RS_STD;
        endcase
    end

    // state register: mode chosen only here, at reset
    always_ff @(posedge rd_clk) begin
        if (mrst) state <= ft_mode ? RS_FT_DRY : RS_STD;
        else      state <= nxt;
    end

    // pointer, data and flag registers
    always_ff @(posedge rd_clk) begin
        if (mrst) begin
            rptr         <= '0;
            rd_data      <= '0;
            ef_s1        <= 1'b0;
            ef_s2        <= 1'b0;
            almost_empty <= 1'b0;
            rd_oe        <= 1'b0;
            ae_thr       <= ofs_load ? ae_offset : DEF_N;
        end else begin
            if (pop)  rptr    <= rptr + 1'b1;
            if (load) rd_data <= mem_q;
            ef_s1        <= (rd_cnt != '0);
            ef_s2        <= ef_s1;
            almost_empty <= rd_cnt > {1'b0, ae_thr};
            rd_oe        <= rd_sel;
        end
    end
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
    import fifo_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int ADDR_W        = 8,
    parameter int DEF_EMPTY_OFS = 127,
    parameter int DEF_FULL_OFS  = 127
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mrst,
    input  logic              ft_mode,
    input  logic              ofs_load,
    input  logic [ADDR_W-1:0] ae_offset,
    input  logic [ADDR_W-1:0] af_offset,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    output logic              wr_flag,
    output logic              almost_empty,
    output logic              almost_full_n,
    output logic              rd_oe
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_go;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [PW-1:0]     wptr_gray;
    logic [PW-1:0]     rptr_gray;
    logic [PW-1:0]     wptr_gray_s;
    logic [PW-1:0]     rptr_gray_s;
    logic [PW-1:0]     wr_cnt;
    logic [PW-1:0]     rd_cnt;
    rd_state_e         rd_state;

    always_ff @(posedge wr_clk) begin
        if (wr_go) mem[wr_addr] <= wr_data;
    end

    fifo_sync2 #(.W(PW)) i_w2r (.clk(rd_clk), .rst(mrst), .d(wptr_gray), .q(wptr_gray_s));
    fifo_sync2 #(.W(PW)) i_r2w (.clk(wr_clk), .rst(mrst), .d(rptr_gray), .q(rptr_gray_s));

    fifo_wr_ctl #(.ADDR_W(ADDR_W), .DEF_FULL_OFS(DEF_FULL_OFS)) i_wr (
        .wr_clk(wr_clk), .mrst(mrst), .ft_mode(ft_mode), .ofs_load(ofs_load),
        .af_offset(af_offset), .wr_en(wr_en), .wr_sel(wr_sel),
        .rptr_gray_s(rptr_gray_s), .wr_go(wr_go), .wr_addr(wr_addr),
        .wptr_gray(wptr_gray), .wr_cnt(wr_cnt), .wr_flag(wr_flag),
        .almost_full_n(almost_full_n)
    );

    fifo_rd_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEF_EMPTY_OFS(DEF_EMPTY_OFS)) i_rd (
        .rd_clk(rd_clk), .mrst(mrst), .ft_mode(ft_mode), .ofs_load(ofs_load),
        .ae_offset(ae_offset), .rd_en(rd_en), .rd_sel(rd_sel),
        .wptr_gray_s(wptr_gray_s), .mem_q(mem[rd_addr]), .rd_addr(rd_addr),
        .rptr_gray(rptr_gray), .rd_cnt(rd_cnt), .state(rd_state),
        .rd_data(rd_data), .rd_flag(rd_flag), .almost_empty(almost_empty),
        .rd_oe(rd_oe)
    );
endmodule

// File: rtl/fifo_checker.sv
module fifo_checker
    import fifo_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic            wr_clk,
    input logic            rd_clk,
    input logic            mrst,
    input logic            wr_en,
    input logic            wr_sel,
    input logic [ADDR_W:0] wr_cnt,
    input logic [ADDR_W:0] wptr_gray,
    input logic [ADDR_W:0] rd_cnt,
    input logic [ADDR_W:0] rptr_gray,
    input rd_state_e       rd_state,
    input logic            rd_flag
);
    localparam logic [ADDR_W:0] FULL_CNT = (ADDR_W + 1)'(1 << ADDR_W);

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (mrst)
        (wr_cnt == FULL_CNT && wr_en && wr_sel) |=> $stable(wptr_gray)); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (mrst)
        (rd_cnt == '0) |=> $stable(rptr_gray)); // R7

    AST_MODE_HELD_STD: assert property (@(posedge rd_clk) disable iff (mrst)
        (rd_state == RS_STD) |=> (rd_state == RS_STD)); // R1

    AST_MODE_HELD_FT: assert property (@(posedge rd_clk) disable iff (mrst)
        (rd_state != RS_STD) |=> (rd_state != RS_STD)); // R1

    AST_EMPTY_TWO_STAGE: assert property (@(posedge rd_clk) disable iff (mrst)
        (rd_state == RS_STD) |-> (rd_flag == ($past(rd_cnt, 2) != '0))); // R8

    AST_FT_FIRST_WORD: assert property (@(posedge rd_clk) disable iff (mrst)
        ((rd_state != RS_STD) && $rose(rd_flag)) |-> ($past(rd_cnt) != '0)); // R3
endmodule

bind dual_mode_fifo fifo_checker #(.ADDR_W(ADDR_W)) i_fifo_checker (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_cnt(wr_cnt), .wptr_gray(wptr_gray), .rd_cnt(rd_cnt), .rptr_gray(rptr_gray),
    .rd_state(rd_state), .rd_flag(rd_flag)
);

// File: tb/test_dual_mode_fifo.sv
`timescale 1ns/100ps
module test_dual_mode_fifo;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;
    localparam int DEF_OFS = 3;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          mrst = 1'b1;
    logic          ft_mode = 1'b0;
    logic          ofs_load = 1'b0;
    logic [AW-1:0] ae_offset = '0;
    logic [AW-1:0] af_offset = '0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          rd_sel = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_flag, wr_flag, almost_empty, almost_full_n, rd_oe;

    int n_chk = 0;
    int n_fail = 0;
    int rcnt = 0;
    int mark = 0;
    int exp_q [DEPTH];

    always #4 wr_clk = ~wr_clk;                   // 125 MHz write clock
    initial begin #1.5; forever #5 rd_clk = ~rd_clk; end
    always @(posedge rd_clk) rcnt <= rcnt + 1;

    dual_mode_fifo #(.DATA_W(DW), .ADDR_W(AW), .DEF_EMPTY_OFS(DEF_OFS),
                     .DEF_FULL_OFS(DEF_OFS)) i_dual_mode_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .ft_mode(ft_mode),
        .ofs_load(ofs_load), .ae_offset(ae_offset), .af_offset(af_offset),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en),
        .rd_sel(rd_sel), .rd_data(rd_data), .rd_flag(rd_flag), .wr_flag(wr_flag),
        .almost_empty(almost_empty), .almost_full_n(almost_full_n), .rd_oe(rd_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk); wr_en = 1'b1; wr_sel = 1'b1; wr_data = d;
        @(posedge wr_clk); mark = rcnt;
        @(negedge wr_clk); wr_en = 1'b0; wr_sel = 1'b0;
    endtask

    task automatic pull();
        @(negedge rd_clk); rd_en = 1'b1; rd_sel = 1'b1;
        @(negedge rd_clk); rd_en = 1'b0; rd_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (10) @(negedge rd_clk);
        repeat (10) @(negedge wr_clk);
    endtask

    task automatic flags(input int cnt, input int n, input int m, input string tag);
        check({tag, " R6 wr_flag"}, int'(wr_flag), int'(cnt < DEPTH));
        check({tag, " R5 almost_full_n"}, int'(almost_full_n), int'(cnt < DEPTH - m));
        check({tag, " R4 almost_empty"}, int'(almost_empty), int'(cnt > n));
        check({tag, " R2 rd_flag"}, int'(rd_flag), int'(cnt > 0));
    endtask

    task automatic run(input int run_id, input logic ft, input logic prog,
                       input int n_in, input int m_in);
        int n, m, d;
        n = prog ? n_in : DEF_OFS;
        m = prog ? m_in : DEF_OFS;
        @(negedge rd_clk);
        mrst = 1'b1; ft_mode = ft; ofs_load = prog;
        ae_offset = AW'(n_in); af_offset = AW'(m_in);
        repeat (6) @(negedge rd_clk);
        @(negedge wr_clk); mrst = 1'b0;
        repeat (2) @(negedge rd_clk);
        // R11 reset state
        check("R11 rd_flag", int'(rd_flag), 0);
        check("R11 wr_flag", int'(wr_flag), 1);
        check("R11 almost_empty", int'(almost_empty), 0);
        check("R11 almost_full_n", int'(almost_full_n), 1);
        check("R11 rd_oe", int'(rd_oe), 0);
        check("R11 rd_data", int'(rd_data), 0);
        // R1 / R9: pins change after reset and must be ignored
        ft_mode = ~ft; ofs_load = ~prog;
        ae_offset = ~AW'(n_in); af_offset = ~AW'(m_in);
        // fill sweep, one word beyond capacity
        for (int k = 1; k <= DEPTH + 1; k++) begin
            d = (k * 29 + run_id * 53 + 1) & 255;
            if (k <= DEPTH) exp_q[k-1] = d;
            push(DW'(d));
            if (ft && k == 1) begin
                while (!rd_flag) @(negedge rd_clk);
                check("R3 first word edge count", rcnt - mark, 3);
                check("R3 first word data", int'(rd_data), exp_q[0]);
            end
            settle();
            flags((k < DEPTH) ? k : DEPTH, n, m, "fill R9");
            if (ft) check("R3 head on output without read", int'(rd_data), exp_q[0]);
            else    check("R1 R2 no data before read", int'(rd_data), 0);
        end
        // R7 select-only cycle: oe follows, data does not move
        @(negedge rd_clk); rd_sel = 1'b1;
        @(negedge rd_clk); rd_sel = 1'b0;
        check("R7 rd_oe high", int'(rd_oe), 1);
        check("R2 sel without enable", int'(rd_data), ft ? exp_q[0] : 0);
        @(negedge rd_clk);
        check("R7 rd_oe low", int'(rd_oe), 0);
        // drain sweep
        for (int j = 0; j < DEPTH; j++) begin
            if (ft) check("R10 ft order", int'(rd_data), exp_q[j]);
            pull();
            if (!ft) check("R10 std order", int'(rd_data), exp_q[j]);
            if (j == DEPTH - 1) begin
                if (ft) check("R3 flag drops with last read", int'(rd_flag), 0);
                else begin
                    @(negedge rd_clk); check("R8 flag after one edge", int'(rd_flag), 1);
                    @(negedge rd_clk); check("R8 flag after two edges", int'(rd_flag), 0);
                end
            end
            settle();
            flags(DEPTH - 1 - j, n, m, "drain");
        end
        // R7 read while empty is ignored; R6 discarded word never shows
        pull();
        settle();
        check("R7 empty read keeps data", int'(rd_data), exp_q[DEPTH-1]);
        check("R6 overflow word dropped", int'(rd_flag), 0);
        d = (run_id * 53 + 200) & 255;
        push(DW'(d));
        settle();
        if (!ft) pull();
        check("R10 word after refill", int'(rd_data), d);
        if (!ft) begin settle(); check("R2 empty again", int'(rd_flag), 0); end
    endtask

    initial begin
        repeat (100000) @(posedge wr_clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        run(0, 1'b0, 1'b0, 9, 9);
        run(1, 1'b1, 1'b1, 5, 2);
        run(2, 1'b0, 1'b1, 0, 0);
        run(3, 1'b1, 1'b1, 15, 15);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule